// File: doc/BRIEF.md
# Converter Serial Slave Readout Port

This block is the serial output side of a successive-approximation converter when the host owns the data clock. A conversion stub supplies an 18-bit result and a busy flag. The block loads the result into a shift register when busy falls. It then sends the result out most significant bit first, one bit for each host clock pulse, while the host holds select and read both low. The host clock is oversampled by the system clock, so each host clock level must last at least two system cycles.

There are two read modes. In after-conversion mode the host reads once busy has dropped, and clock pulses that arrive during a conversion are ignored. In during-conversion mode the host reads the previous result while the next conversion runs. If that read is still unfinished when the conversion completes, a one-cycle read-error pulse is raised. A serial input is captured on the clock edge opposite the shift edge. Several devices can therefore be chained, with the upstream device's output wired to the downstream device's input, and the host reads every result from the last device in one long burst.

Top module: `adc_slave_port`

## Requirements
- R1: After synchronous reset, `sdo` and `rd_err` are both 0.
- R2: The result is sent MSB first. The MSB is on `sdo` as soon as the device is selected. Each shift edge advances `sdo` by one bit, so the 18 bits need 18 pulses.
- R3: Host clock edges have no effect unless `cs_n` and `rd_n` are both low. Edges that arrive while deselected leave the read position unchanged.
- R4: With `sclk_inv` = 0, the clock idles high. A falling edge latches `sdi` and the following rising edge shifts. With `sclk_inv` = 1 the roles swap and the clock idles low. Each pulse is a latch edge followed by a shift edge.
- R5: After the device's own 18 bits, `sdo` presents the bits latched from `sdi`, in the order they were latched. In a two-device chain the host receives 36 bits: the downstream result, then the upstream result.
- R6: A falling edge of `busy` loads `result` and returns the read position to the MSB. In after-conversion mode (`mode` = 0), shift edges that arrive while `busy` is high are ignored.
- R7: In during-conversion mode (`mode` = 1), the result loaded at the previous busy fall stays readable while `busy` is high. The new result replaces it only at the next busy fall.
- R8: In during-conversion mode, a busy fall that arrives while the device is selected and fewer than 18 bits have been shifted raises `rd_err` for exactly one system cycle. The pulse starts on the cycle after the fall.
- R9: `rd_err` never rises in after-conversion mode.
- R10: Raising `cs_n` or `rd_n` abandons the read. The next selection starts again at the MSB of the held result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | 0 = read after conversion, 1 = read during conversion |
| sclk_inv | input | 1 | Selects which host clock edge shifts and which latches |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read enable, active low |
| sclk | input | 1 | Host-supplied serial clock |
| sdi | input | 1 | Serial input for chaining |
| busy | input | 1 | Conversion in progress, from the converter stub |
| result | input | 18 | Conversion result, sampled when busy falls |
| sdo | output | 1 | Serial data output |
| rd_err | output | 1 | One-cycle pulse on an incomplete read during conversion |

## Verification
The hardest condition to reach is a busy fall that lands in the middle of a read in during-conversion mode. To get there, the stimulus starts a conversion, selects the device, clocks out only part of the previous result and then drops busy with select still held. It checks that one single-cycle error pulse appears and that the new result is then readable from the MSB. The chained pair is equally hard to observe from outside, because the upstream bits only appear after exactly 18 downstream shifts. The bench drives two instances from a shared clock in both clock polarities and compares all 36 bits against a per-cycle behavioural model of each device.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;

    localparam int unsigned ADC_RES_W = 18;

    typedef enum logic {
        RD_AFTER  = 1'b0,
        RD_DURING = 1'b1
    } rd_mode_e;

    typedef struct packed {
        logic shift;
        logic latch;
    } sclk_evt_t;

    // Maps raw clock transitions to shift/latch events for the chosen polarity.
    function automatic sclk_evt_t map_edges(logic rise, logic fall, logic inv);
        sclk_evt_t e;
        e.shift = inv ? fall : rise;
        e.latch = inv ? rise : fall;
        return e;
    endfunction

endpackage

// File: rtl/adc_sp_edge.sv
module adc_sp_edge
    import adc_sp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sclk,
    input  logic      inv,
    output sclk_evt_t evt
);
    logic sclk_d;

    always_ff @(posedge clk) begin
        if (rst) sclk_d <= 1'b0;
        else     sclk_d <= sclk;
    end

    always_comb begin
        evt = map_edges(sclk & ~sclk_d, ~sclk & sclk_d, inv);
    end
endmodule

// File: rtl/adc_sp_shifter.sv
module adc_sp_shifter #(
    parameter int unsigned W  = 18,
    localparam int unsigned CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [W-1:0]  load_val,
    input  logic          restart,
    input  logic          shift,
    input  logic          latch,
    input  logic          sdi,
    output logic          sdo,
    output logic [CW-1:0] cnt
);
    logic [W-1:0]  held_q;
    logic [W-1:0]  shreg_q;
    logic          cap_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q  <= '0;
            shreg_q <= '0;
            cap_q   <= 1'b0;
            cnt_q   <= '0;
        end else begin
            if (load) begin
                held_q  <= load_val;
                shreg_q <= load_val;
                cnt_q   <= '0;
            end else if (restart) begin
                shreg_q <= held_q;
                cnt_q   <= '0;
            end else if (shift) begin
                shreg_q <= {shreg_q[W-2:0], cap_q};
                if (cnt_q != CW'(W)) cnt_q <= cnt_q + 1'b1;
            end
            if (latch) cap_q <= sdi;
        end
    end

    assign sdo = shreg_q[W-1];
    assign cnt = cnt_q;
endmodule

// File: rtl/adc_sp_err.sv
module adc_sp_err #(
    parameter int unsigned W  = 18,
    localparam int unsigned CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          busy_fall,
    input  logic          during,
    input  logic          active,
    input  logic [CW-1:0] cnt,
    output logic          rd_err
);
    always_ff @(posedge clk) begin
        if (rst) rd_err <= 1'b0;
        else     rd_err <= busy_fall & during & active & (cnt < CW'(W));
    end
endmodule

// File: rtl/adc_slave_port.sv
module adc_slave_port
    import adc_sp_pkg::*;
#(
    parameter int unsigned W  = ADC_RES_W,
    localparam int unsigned CW = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mode,
    input  logic         sclk_inv,
    input  logic         cs_n,
    input  logic         rd_n,
    input  logic         sclk,
    input  logic         sdi,
    input  logic         busy,
    input  logic [W-1:0] result,
    output logic         sdo,
    output logic         rd_err
);
    rd_mode_e      rmode;
    sclk_evt_t     evt;
    logic          busy_d;
    logic          busy_fall;
    logic          active;
    logic          shift_ok;
    logic [CW-1:0] shift_cnt;

    assign rmode  = rd_mode_e'(mode);
    assign active = ~cs_n & ~rd_n;

    always_ff @(posedge clk) begin
        if (rst) busy_d <= 1'b0;
        else     busy_d <= busy;
    end

    assign busy_fall = busy_d & ~busy;
    assign shift_ok  = active & evt.shift & ((rmode == RD_DURING) | ~busy);

    adc_sp_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .sclk (sclk),
        .inv  (sclk_inv),
        .evt  (evt)
    );

    adc_sp_shifter #(.W(W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (busy_fall),
        .load_val (result),
        .restart  (~active),
        .shift    (shift_ok),
        .latch    (active & evt.latch),
        .sdi      (sdi),
        .sdo      (sdo),
        .cnt      (shift_cnt)
    );

    adc_sp_err #(.W(W)) u_err (
        .clk       (clk),
        .rst       (rst),
        .busy_fall (busy_fall),
        .during    (rmode == RD_DURING),
        .active    (active),
        .cnt       (shift_cnt),
        .rd_err    (rd_err)
    );
endmodule

// File: rtl/adc_sp_chk.sv
module adc_sp_chk #(
    parameter int unsigned W  = 18,
    localparam int unsigned CW = $clog2(W + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          mode,
    input logic          cs_n,
    input logic          rd_n,
    input logic          busy,
    input logic          busy_fall,
    input logic [CW-1:0] shift_cnt,
    input logic          sdo,
    input logic          rd_err
);
    // R8: error pulse lasts a single cycle
    a_r8_err_one_cycle: assert property (@(posedge clk) disable iff (rst)
        rd_err |=> !rd_err);

    // R8: error pulse follows a busy fall
    a_r8_err_after_fall: assert property (@(posedge clk) disable iff (rst)
        rd_err |-> $past(busy_fall));

    // R9: no error in after-conversion mode
    a_r9_err_mode: assert property (@(posedge clk) disable iff (rst)
        rd_err |-> $past(mode));

    // R10: deselection clears the read position
    a_r10_cnt_clear: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(cs_n || rd_n)) |-> (shift_cnt == '0));

    // R6: selected, after-conversion, busy high: output holds
    a_r6_hold_busy: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !cs_n && !rd_n && busy && !mode) |-> $stable(sdo));

    // R2: position never passes the result width
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        shift_cnt <= CW'(W));
endmodule

bind adc_slave_port adc_sp_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .busy      (busy),
    .busy_fall (busy_fall),
    .shift_cnt (shift_cnt),
    .sdo       (sdo),
    .rd_err    (rd_err)
);

// File: tb/test_adc_slave_port.sv
module test_adc_slave_port;
    localparam int N = 18;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode = 1'b0, inv = 1'b0, cs_n = 1'b1, rd_n = 1'b1, sclk = 1'b1, busy = 1'b0;
    logic [N-1:0] res_up = '0, res_dn = '0;
    logic up_sdo, dn_sdo, up_err, dn_err;

    int errors = 0, checks = 0, err_pulses = 0, err_run = 0, err_maxrun = 0;
    bit done = 0;

    always #10 clk = ~clk;

    adc_slave_port i_adc_slave_port_up (
        .clk(clk), .rst(rst), .mode(mode), .sclk_inv(inv), .cs_n(cs_n), .rd_n(rd_n),
        .sclk(sclk), .sdi(1'b0), .busy(busy), .result(res_up), .sdo(up_sdo), .rd_err(up_err));

    adc_slave_port i_adc_slave_port (
        .clk(clk), .rst(rst), .mode(mode), .sclk_inv(inv), .cs_n(cs_n), .rd_n(rd_n),
        .sclk(sclk), .sdi(up_sdo), .busy(busy), .result(res_dn), .sdo(dn_sdo), .rd_err(dn_err));

    // Behavioural reference: index 0 = upstream, 1 = downstream
    logic [N-1:0] m_held [2];
    int           m_n    [2];
    bit           m_capq [2][0:127];
    bit           m_cap  [2];
    bit           m_err  [2];
    bit           m_sclk, m_busy;

    function automatic bit m_sdo(int d);
        if (m_n[d] < N) return m_held[d][N-1-m_n[d]];
        return m_capq[d][m_n[d]-N];
    endfunction

    always @(posedge clk) begin
        bit rise, fall, sh, la, bf, act;
        bit sdi_in [2];
        if (rst) begin
            for (int d = 0; d < 2; d++) begin
                m_held[d] = '0; m_n[d] = 0; m_cap[d] = 0; m_err[d] = 0;
            end
            m_sclk = 0; m_busy = 0;
        end else begin
            rise = sclk && !m_sclk;
            fall = !sclk && m_sclk;
            sh   = inv ? fall : rise;
            la   = inv ? rise : fall;
            bf   = m_busy && !busy;
            act  = !cs_n && !rd_n;
            sdi_in[0] = 1'b0;
            sdi_in[1] = m_sdo(0);
            for (int d = 0; d < 2; d++) begin
                m_err[d] = mode && bf && act && (m_n[d] < N);
                if (bf) begin
                    m_held[d] = (d == 0) ? res_up : res_dn;
                    m_n[d] = 0;
                end else if (!act) begin
                    m_n[d] = 0;
                end else if (sh && (mode || !busy)) begin
                    if (m_n[d] < 127) begin
                        m_capq[d][m_n[d]] = m_cap[d];
                        m_n[d] = m_n[d] + 1;
                    end
                end
                if (la && act) m_cap[d] = sdi_in[d];
            end
            m_busy = busy;
            m_sclk = sclk;
        end
    end

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-cycle model comparison
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(up_sdo === m_sdo(0), "R2/R5 model up sdo", up_sdo, m_sdo(0));
            check(dn_sdo === m_sdo(1), "R2/R5 model dn sdo", dn_sdo, m_sdo(1));
            check(dn_err === m_err[1], "R8 model rd_err", dn_err, m_err[1]);
        end
    end

    always @(posedge clk) begin
        if (!rst && dn_err) begin
            if (err_run == 0) err_pulses++;
            err_run++;
            if (err_run > err_maxrun) err_maxrun = err_run;
        end else err_run = 0;
    end

    task automatic pulse(output bit b);
        @(negedge clk);
        b = dn_sdo;
        sclk = inv ? 1'b1 : 1'b0;
        repeat (2) @(negedge clk);
        sclk = inv ? 1'b0 : 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic read_bits(int n, output logic [2*N-1:0] v);
        bit b;
        v = '0;
        for (int i = 0; i < n; i++) begin
            pulse(b);
            v = {v[2*N-2:0], b};
        end
    endtask

    task automatic conv(logic [N-1:0] u, logic [N-1:0] d);
        @(negedge clk);
        busy = 1'b1;
        repeat (3) @(negedge clk);
        res_up = u; res_dn = d;
        repeat (3) @(negedge clk);
        busy = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic sel(bit on);
        @(negedge clk);
        cs_n = !on; rd_n = !on;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [2*N-1:0] v;
        int pulses0;
        bit b;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(dn_sdo == 1'b0, "R1 reset sdo", dn_sdo, 0);
        check(dn_err == 1'b0, "R1 reset rd_err", dn_err, 0);

        // R2 R4 R5: after-conversion chain read, clock idles high
        conv(18'h2A5C3, 18'h15A3C);
        sel(1);
        check(dn_sdo == res_dn[N-1], "R2 MSB present on select", dn_sdo, res_dn[N-1]);
        read_bits(2*N, v);
        check(v == {res_dn, res_up}, "R5 chain 36 bits inv=0", v, {res_dn, res_up});
        sel(0);

        // R4: swapped polarity, clock idles low
        inv = 1'b1; sclk = 1'b0;
        conv(18'h0F0F1, 18'h3C3C2);
        sel(1);
        read_bits(2*N, v);
        check(v == {res_dn, res_up}, "R4 chain 36 bits inv=1", v, {res_dn, res_up});
        sel(0);

        // R3: pulses while deselected or rd_n high are ignored
        for (int i = 0; i < 6; i++) pulse(b);
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b1;
        for (int i = 0; i < 6; i++) pulse(b);
        check(dn_sdo == res_dn[N-1], "R3 ignored edges keep MSB", dn_sdo, res_dn[N-1]);
        sel(1);
        read_bits(N, v);
        check(v[N-1:0] == res_dn, "R3 full read after ignored edges", v[N-1:0], res_dn);
        sel(0);

        // R6 R9: after-conversion, shifting while busy is ignored, fall while selected
        inv = 1'b0; sclk = 1'b1;
        pulses0 = err_pulses;
        sel(1);
        @(negedge clk); busy = 1'b1; res_dn = 18'h12345; res_up = 18'h0ABCD;
        for (int i = 0; i < 5; i++) pulse(b);
        check(dn_sdo == 1'b1, "R6 busy-gated sdo holds MSB (3C3C2)", dn_sdo, 1);
        @(negedge clk); busy = 1'b0;
        repeat (3) @(negedge clk);
        check(err_pulses == pulses0, "R9 no rd_err in after mode", err_pulses, pulses0);
        read_bits(N, v);
        check(v[N-1:0] == 18'h12345, "R6 new result after busy fall", v[N-1:0], 18'h12345);
        sel(0);

        // R10: abort and restart
        sel(1);
        read_bits(5, v);
        sel(0);
        sel(1);
        read_bits(N, v);
        check(v[N-1:0] == 18'h12345, "R10 restart from MSB", v[N-1:0], 18'h12345);
        sel(0);

        // R7: during-conversion read of previous result
        mode = 1'b1;
        conv(18'h01111, 18'h2D00D);
        pulses0 = err_pulses;
        @(negedge clk); busy = 1'b1; res_dn = 18'h1BEEF; res_up = 18'h00777;
        sel(1);
        read_bits(N, v);
        check(v[N-1:0] == 18'h2D00D, "R7 previous result during busy", v[N-1:0], 18'h2D00D);
        sel(0);
        @(negedge clk); busy = 1'b0;
        repeat (3) @(negedge clk);
        check(err_pulses == pulses0, "R8 no error after complete read", err_pulses, pulses0);
        sel(1);
        read_bits(N, v);
        check(v[N-1:0] == 18'h1BEEF, "R7 new result after fall", v[N-1:0], 18'h1BEEF);
        sel(0);

        // R8: truncated read during conversion
        pulses0 = err_pulses;
        @(negedge clk); busy = 1'b1; res_dn = 18'h3A5A5;
        sel(1);
        read_bits(7, v);
        check(v[6:0] == 7'(18'h1BEEF >> 11), "R7 partial read bits", v[6:0], 7'(18'h1BEEF >> 11));
        @(negedge clk); busy = 1'b0;
        repeat (4) @(negedge clk);
        check(err_pulses == pulses0 + 1, "R8 one error pulse", err_pulses, pulses0 + 1);
        check(err_maxrun == 1, "R8 pulse width one cycle", err_maxrun, 1);
        read_bits(N, v);
        check(v[N-1:0] == 18'h3A5A5, "R6 reload after truncated read", v[N-1:0], 18'h3A5A5);
        sel(0);

        repeat (4) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule